// File: doc/BRIEF.md
# Scatter-Gather Transmit Fetch Engine

This block is the bus-master front end of a transmit path. Software places a descriptor in host memory and writes its byte address into the list pointer. The engine then reads the descriptor word by word. It picks up the chain link and the header, and for each fragment it reads the fragment address and its length word. It fetches the fragment bytes and sends them one at a time to the transmit FIFO, in address order, across any byte alignment. A flag in a fragment's length word ends the packet.

When the packet has been gathered, the engine reports completion to the status unit and loads the list pointer with the descriptor's chain link, which is zero for a lone descriptor. A header flag can also request a transmit-complete event. Descriptor faults raise a host-error event. These faults are a bad alignment, fragment lengths that do not add up to the header total, and a fragment list that never ends. A command input can halt and resume the memory traffic at any point.

The memory port is a plain word-read port. A request is taken when `mem_ready` is high, and its data returns later on `mem_rvalid`. The engine never has more than one read outstanding.

Top module: `dn_dma_engine`

## Requirements
- R1: After reset the list pointer reads zero, `mem_req` and `tx_valid` are low, and no event pulses.
- R2: For a descriptor at byte address P, the engine reads the chain link at P, the header at P+4, fragment k's address at P+8+8k and its length at P+12+8k. Fragment bytes are read from the word at the address with bits 1:0 cleared, byte lane n taking bits 8n+7:8n, and they leave `tx_data` in ascending address order.
- R3: Only bits 12:0 of a fragment length word count bytes, and bits 30:13 are ignored. A fragment of length zero produces no bytes and no data read.
- R4: Bit 31 of a fragment length word marks the final fragment. No further fragment words are read after it.
- R5: `tx_last` is high on exactly the byte whose running count equals header bits 12:0. This holds even when the final fragment is empty.
- R6: Once the final fragment's bytes have all left, `dn_done` pulses for one cycle. `tx_done` pulses in the same cycle only if header bit 15 was set. The list pointer then reads the chain-link value.
- R7: If the fragment lengths do not sum to the header total, `host_err` pulses instead of `dn_done`, and the list pointer keeps the descriptor address.
- R8: A write of a nonzero address with bits 2:0 not all zero is rejected. `host_err` pulses, no memory read is made, and the list pointer is unchanged.
- R9: `ctl_valid` with `ctl_arg` = 2 halts the engine, and `ctl_arg` = 3 resumes it. While halted, a read already accepted still completes, but no new request is issued. A descriptor written while halted waits.
- R10: If a descriptor holds MAX_SEGS fragments and none carries the final flag, `host_err` pulses and the engine stops.
- R11: At most one memory read is outstanding. `tx_data` and `tx_last` hold steady while `tx_valid` is high and `tx_ready` is low.
- R12: A list-pointer write of zero, or any write while a descriptor is in progress, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lp_wr | input | 1 | List-pointer write strobe |
| lp_wdata | input | 32 | Descriptor byte address to write |
| lp_rdata | output | 32 | List-pointer read-back |
| ctl_valid | input | 1 | Control command strobe |
| ctl_arg | input | 4 | Command argument: 2 halts, 3 resumes |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Word-aligned read address |
| mem_ready | input | 1 | Request accepted when high with `mem_req` |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte available for the FIFO |
| tx_data | output | 8 | Packet byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_ready | input | 1 | FIFO accepts the byte |
| dn_done | output | 1 | Download-complete event pulse |
| tx_done | output | 1 | Transmit-complete event pulse |
| host_err | output | 1 | Host-error event pulse |

## Verification
A wrong fragment pointer or remaining-count shows up directly at the byte stream. The first byte that leaves from the wrong lane or wrong address fails its comparison, within a few cycles of that fragment's first data read. A wrong running sum or a missed final flag stays hidden until the packet ends. It then appears as a misplaced `tx_last`, a `host_err` in place of `dn_done`, or the reverse, and the list-pointer read-back confirms which path was taken. Stall faults show as memory requests accepted while halted, which the memory model counts cycle by cycle.

// File: rtl/dn_pkg.sv
// Shared types for the transmit fetch engine.
// Assumes 32-bit descriptor and data words.
package dn_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LINK,
        ST_HDR,
        ST_SADDR,
        ST_SLEN,
        ST_DATA,
        ST_DRAIN
    } dn_state_e;

    localparam logic [3:0] CMD_HALT   = 4'd2;
    localparam logic [3:0] CMD_RESUME = 4'd3;
endpackage

// File: rtl/dn_desc_walker.sv
// Descriptor walker: owns the list pointer, the halt flag and the memory
// read port. It parses the chain link, header and fragment words, then
// issues data-word reads and hands each word to the byte packer with a
// start lane and byte count.
// Assumes: one read outstanding, responses only after acceptance, and
// the packer consumes a whole word before the next data read is issued.
module dn_desc_walker
    import dn_pkg::*;
#(
    parameter int MAX_SEGS = 64,
    parameter int LEN_W    = 13,
    parameter int SUM_W    = LEN_W + $clog2(MAX_SEGS) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lp_wr,
    input  logic [31:0]      lp_wdata,
    input  logic             ctl_valid,
    input  logic [3:0]       ctl_arg,
    output logic             mem_req,
    output logic [31:0]      mem_addr,
    input  logic             mem_ready,
    input  logic             mem_rvalid,
    input  logic [31:0]      mem_rdata,
    output logic             pk_start,
    output logic             pk_load,
    output logic [31:0]      pk_word,
    output logic [1:0]       pk_off,
    output logic [2:0]       pk_cnt,
    input  logic             pk_busy,
    output logic [LEN_W-1:0] hdr_total,
    output logic [31:0]      lp_q,
    output logic             dn_done,
    output logic             tx_done,
    output logic             host_err
);
    localparam int IDX_W = $clog2(MAX_SEGS) + 1;

    dn_state_e        state;
    logic [31:0]      link_q;
    logic             notify_q;
    logic [IDX_W-1:0] seg_idx;
    logic [31:0]      seg_ptr;
    logic [LEN_W-1:0] seg_left;
    logic             seg_final;
    logic [SUM_W-1:0] sum_q;
    logic             inflight;
    logic             halted;

    logic [LEN_W-1:0] rd_len;
    logic [2:0]       avail;
    logic [2:0]       take;
    logic             seg_end;
    logic             end_final;
    logic             need_fetch;
    logic [31:0]      desc_addr;
    logic             wr_ok;
    logic             wr_bad;

    // Decode the list-pointer write presented while idle.
    always_comb begin
        wr_ok  = (state == ST_IDLE) && lp_wr && (lp_wdata != 32'd0) && (lp_wdata[2:0] == 3'd0);
        wr_bad = (state == ST_IDLE) && lp_wr && (lp_wdata != 32'd0) && (lp_wdata[2:0] != 3'd0);
    end

    // Bytes taken from the current data word and fragment-end detection.
    always_comb begin
        rd_len    = mem_rdata[LEN_W-1:0];
        avail     = 3'd4 - {1'b0, seg_ptr[1:0]};
        take      = (seg_left < LEN_W'(avail)) ? seg_left[2:0] : avail;
        seg_end   = mem_rvalid && (((state == ST_SLEN) && (rd_len == '0)) ||
                                   ((state == ST_DATA) && (seg_left == LEN_W'(take))));
        end_final = (state == ST_SLEN) ? mem_rdata[31] : seg_final;
    end

    // Select the read address and decide whether a read is wanted.
    always_comb begin
        desc_addr = lp_q + 32'd8 + (32'(seg_idx) << 3);
        unique case (state)
            ST_LINK:  mem_addr = lp_q;
            ST_HDR:   mem_addr = lp_q + 32'd4;
            ST_SADDR: mem_addr = desc_addr;
            ST_SLEN:  mem_addr = desc_addr + 32'd4;
            ST_DATA:  mem_addr = {seg_ptr[31:2], 2'b00};
            default:  mem_addr = 32'd0;
        endcase
        need_fetch = (state == ST_LINK) || (state == ST_HDR) || (state == ST_SADDR) ||
                     (state == ST_SLEN) || ((state == ST_DATA) && !pk_busy);
        mem_req    = need_fetch && !inflight && !halted;
    end

    // Hand data words to the packer.
    always_comb begin
        pk_start = wr_ok;
        pk_load  = mem_rvalid && (state == ST_DATA);
        pk_word  = mem_rdata;
        pk_off   = seg_ptr[1:0];
        pk_cnt   = take;
    end

    // Halt flag from the control command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            halted <= 1'b0;
        else if (ctl_valid && (ctl_arg == CMD_HALT))
            halted <= 1'b1;
        else if (ctl_valid && (ctl_arg == CMD_RESUME))
            halted <= 1'b0;
    end

    // Track the single outstanding read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            inflight <= 1'b0;
        else if (mem_req && mem_ready)
            inflight <= 1'b1;
        else if (mem_rvalid)
            inflight <= 1'b0;
    end

    // Descriptor state machine, list pointer and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            lp_q      <= 32'd0;
            link_q    <= 32'd0;
            hdr_total <= '0;
            notify_q  <= 1'b0;
            seg_idx   <= '0;
            seg_ptr   <= 32'd0;
            seg_left  <= '0;
            seg_final <= 1'b0;
            sum_q     <= '0;
            dn_done   <= 1'b0;
            tx_done   <= 1'b0;
            host_err  <= 1'b0;
        end else begin
            dn_done  <= 1'b0;
            tx_done  <= 1'b0;
            host_err <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (wr_ok) begin
                        lp_q    <= lp_wdata;
                        seg_idx <= '0;
                        sum_q   <= '0;
                        state   <= ST_LINK;
                    end else if (wr_bad) begin
                        host_err <= 1'b1;
                    end
                end
                ST_LINK: if (mem_rvalid) begin
                    link_q <= mem_rdata;
                    state  <= ST_HDR;
                end
                ST_HDR: if (mem_rvalid) begin
                    hdr_total <= mem_rdata[LEN_W-1:0];
                    notify_q  <= mem_rdata[15];
                    state     <= ST_SADDR;
                end
                ST_SADDR: if (mem_rvalid) begin
                    seg_ptr <= mem_rdata;
                    state   <= ST_SLEN;
                end
                ST_SLEN: if (mem_rvalid) begin
                    seg_left  <= rd_len;
                    seg_final <= mem_rdata[31];
                    sum_q     <= sum_q + SUM_W'(rd_len);
                    if (rd_len != '0)
                        state <= ST_DATA;
                end
                ST_DATA: if (mem_rvalid) begin
                    seg_ptr  <= seg_ptr + 32'(take);
                    seg_left <= seg_left - LEN_W'(take);
                end
                ST_DRAIN: if (!pk_busy) begin
                    if (sum_q == SUM_W'(hdr_total)) begin
                        dn_done <= 1'b1;
                        tx_done <= notify_q;
                        lp_q    <= link_q;
                    end else begin
                        host_err <= 1'b1;
                    end
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
            if (seg_end) begin
                if (end_final) begin
                    state <= ST_DRAIN;
                end else if (seg_idx == IDX_W'(MAX_SEGS - 1)) begin
                    host_err <= 1'b1;
                    state    <= ST_IDLE;
                end else begin
                    seg_idx <= seg_idx + 1'b1;
                    state   <= ST_SADDR;
                end
            end
        end
    end

    AST_MISALIGN_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bad |=> (host_err && !mem_req && (state == ST_IDLE))); // R8
    AST_EVENT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dn_done, host_err})); // R7
    AST_TXDONE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> dn_done); // R6
    AST_DONE_LOADS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        dn_done |-> (lp_q == $past(link_q))); // R6
    AST_HALT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !(ctl_valid && (ctl_arg == CMD_RESUME))) |=> !mem_req); // R9
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> !mem_req); // R11
endmodule

// File: rtl/dn_byte_packer.sv
// Byte packer: holds one fetched word and emits its selected byte lanes,
// lowest lane first, over a valid/ready byte interface. Counts the bytes
// of the packet to mark the one that reaches the header total.
// Assumes: a new word is loaded only when the previous one is used up.
module dn_byte_packer #(
    parameter int LEN_W = 13,
    parameter int SUM_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pk_start,
    input  logic             pk_load,
    input  logic [31:0]      pk_word,
    input  logic [1:0]       pk_off,
    input  logic [2:0]       pk_cnt,
    input  logic [LEN_W-1:0] hdr_total,
    output logic             pk_busy,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    input  logic             tx_ready
);
    logic [31:0]      word_q;
    logic [1:0]       lane_q;
    logic [2:0]       left_q;
    logic [SUM_W-1:0] sent_q;

    // Present the current lane and the end-of-packet mark.
    always_comb begin
        pk_busy  = (left_q != 3'd0);
        tx_valid = pk_busy;
        tx_data  = word_q[{lane_q, 3'b000} +: 8];
        tx_last  = tx_valid && ((sent_q + 1'b1) == SUM_W'(hdr_total));
    end

    // Word holding register and lane stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= 32'd0;
            lane_q <= 2'd0;
            left_q <= 3'd0;
        end else if (pk_load) begin
            word_q <= pk_word;
            lane_q <= pk_off;
            left_q <= pk_cnt;
        end else if (tx_valid && tx_ready) begin
            lane_q <= lane_q + 1'b1;
            left_q <= left_q - 1'b1;
        end
    end

    // Packet byte counter, cleared when a descriptor starts.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sent_q <= '0;
        else if (pk_start)
            sent_q <= '0;
        else if (tx_valid && tx_ready)
            sent_q <= sent_q + 1'b1;
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R11
    AST_LOAD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pk_load |-> !pk_busy); // R11
endmodule

// File: rtl/dn_dma_engine.sv
// Transmit fetch engine top: joins the descriptor walker and the byte
// packer. Memory port is word-based with one read outstanding; the byte
// stream feeds a transmit FIFO.
module dn_dma_engine #(
    parameter int MAX_SEGS = 64,
    parameter int LEN_W    = 13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lp_wr,
    input  logic [31:0] lp_wdata,
    output logic [31:0] lp_rdata,
    input  logic        ctl_valid,
    input  logic [3:0]  ctl_arg,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_ready,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        dn_done,
    output logic        tx_done,
    output logic        host_err
);
    localparam int SUM_W = LEN_W + $clog2(MAX_SEGS) + 1;

    logic             pk_start;
    logic             pk_load;
    logic [31:0]      pk_word;
    logic [1:0]       pk_off;
    logic [2:0]       pk_cnt;
    logic             pk_busy;
    logic [LEN_W-1:0] hdr_total;

    dn_desc_walker #(
        .MAX_SEGS (MAX_SEGS),
        .LEN_W    (LEN_W),
        .SUM_W    (SUM_W)
    ) i_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .lp_wr      (lp_wr),
        .lp_wdata   (lp_wdata),
        .ctl_valid  (ctl_valid),
        .ctl_arg    (ctl_arg),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ready  (mem_ready),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .pk_start   (pk_start),
        .pk_load    (pk_load),
        .pk_word    (pk_word),
        .pk_off     (pk_off),
        .pk_cnt     (pk_cnt),
        .pk_busy    (pk_busy),
        .hdr_total  (hdr_total),
        .lp_q       (lp_rdata),
        .dn_done    (dn_done),
        .tx_done    (tx_done),
        .host_err   (host_err)
    );

    dn_byte_packer #(
        .LEN_W (LEN_W),
        .SUM_W (SUM_W)
    ) i_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .pk_start  (pk_start),
        .pk_load   (pk_load),
        .pk_word   (pk_word),
        .pk_off    (pk_off),
        .pk_cnt    (pk_cnt),
        .hdr_total (hdr_total),
        .pk_busy   (pk_busy),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_last   (tx_last),
        .tx_ready  (tx_ready)
    );

    AST_DRAINED_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        dn_done |-> !tx_valid); // R6
endmodule

// File: tb/test_dn_dma_engine.sv
// Scoreboard bench: tasks build descriptors in a memory model and queue
// the expected bytes; a monitor pops and compares bytes as they leave.
module test_dn_dma_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lp_wr = 1'b0;
    logic [31:0] lp_wdata = 32'd0;
    logic [31:0] lp_rdata;
    logic        ctl_valid = 1'b0;
    logic [3:0]  ctl_arg = 4'd0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ready = 1'b1;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = 32'd0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        tx_ready = 1'b1;
    logic        dn_done;
    logic        tx_done;
    logic        host_err;

    dn_dma_engine i_dn_dma_engine (
        .clk(clk), .rst_n(rst_n), .lp_wr(lp_wr), .lp_wdata(lp_wdata), .lp_rdata(lp_rdata),
        .ctl_valid(ctl_valid), .ctl_arg(ctl_arg), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .dn_done(dn_done), .tx_done(tx_done), .host_err(host_err)
    );

    always #10 clk = ~clk;

    logic [31:0] mem [0:1023];
    logic [8:0]  exp_q [$];
    int checks = 0, errors = 0;
    int n_dn = 0, n_txc = 0, n_herr = 0, n_acc = 0, n_bytes = 0, n_overlap = 0;
    int exp_cnt = 0, exp_total = 0;
    int mem_lat = 1;
    bit bp_mode = 1'b0, rdy_mode = 1'b0, finished = 1'b0;
    bit pend = 1'b0;
    int pend_cnt = 0;
    logic [31:0] pend_addr = 32'd0;

    function automatic logic [7:0] byte_at(input logic [31:0] a);
        return mem[a[11:2]][{a[1:0], 3'b000} +: 8];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Memory model, byte monitor and event counters, all at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (pend && pend_cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem[pend_addr[11:2]];
                pend = 1'b0;
            end else if (pend) begin
                pend_cnt--;
            end
            mem_ready = rdy_mode ? ~mem_ready : 1'b1;
            tx_ready  = bp_mode ? ~tx_ready : 1'b1;
            #1;
            if (mem_req && mem_ready) begin
                if (pend || mem_rvalid) n_overlap++;
                pend = 1'b1; pend_cnt = mem_lat - 1; pend_addr = mem_addr; n_acc++;
            end
            if (tx_valid && tx_ready) begin
                n_bytes++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected byte", {23'd0, tx_last, tx_data}, 32'd0);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    check({tx_last, tx_data} == e, "R2/R5", "byte+last", {23'd0, tx_last, tx_data}, {23'd0, e});
                end
            end
            if (dn_done) n_dn++;
            if (tx_done) n_txc++;
            if (host_err) n_herr++;
        end
    end

    task automatic put(input logic [31:0] a, input logic [31:0] v);
        mem[a[11:2]] = v;
    endtask

    task automatic desc(input logic [31:0] base, input logic [31:0] link, input logic [31:0] hdr);
        put(base, link);
        put(base + 4, hdr);
        exp_total = int'(hdr[12:0]);
        exp_cnt = 0;
    endtask

    task automatic seg(input logic [31:0] base, input int k, input logic [31:0] a,
                       input logic [31:0] lenw, input bit push);
        put(base + 8 + 8 * k, a);
        put(base + 12 + 8 * k, lenw);
        if (push) begin
            for (int i = 0; i < int'(lenw[12:0]); i++) begin
                exp_cnt++;
                exp_q.push_back({exp_cnt == exp_total, byte_at(a + i)});
            end
        end
    endtask

    task automatic write_lp(input logic [31:0] v);
        @(negedge clk);
        lp_wr = 1'b1; lp_wdata = v;
        @(negedge clk);
        lp_wr = 1'b0;
    endtask

    task automatic command(input logic [3:0] c);
        @(negedge clk);
        ctl_valid = 1'b1; ctl_arg = c;
        @(negedge clk);
        ctl_valid = 1'b0;
    endtask

    task automatic wait_end(input string req);
        int d0, h0, t;
        d0 = n_dn; h0 = n_herr; t = 0;
        while (n_dn == d0 && n_herr == h0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        check(t < 3000, req, "packet end seen", t, 0);
        repeat (3) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int d0, t0, h0, a0, b0;
        for (int i = 0; i < 1024; i++)
            for (int b = 0; b < 4; b++)
                mem[i][8*b +: 8] = 8'((i * 4 + b) * 13 + 7);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(lp_rdata == 0, "R1", "lp after reset", lp_rdata, 0);
        check(!mem_req && !tx_valid, "R1", "req/valid after reset", {mem_req, tx_valid}, 0);
        check(n_dn + n_txc + n_herr == 0, "R1", "events after reset", n_dn + n_txc + n_herr, 0);

        // R2 R4 R5 R6: single aligned fragment with notify
        desc(32'h100, 32'h0, 32'h8000 | 10);
        seg(32'h100, 0, 32'h800, 32'h8000_0000 | 10, 1'b1);
        d0 = n_dn; t0 = n_txc;
        write_lp(32'h100);
        wait_end("R6");
        check(n_dn == d0 + 1, "R6", "dn_done count", n_dn, d0 + 1);
        check(n_txc == t0 + 1, "R6", "tx_done with notify", n_txc, t0 + 1);
        check(lp_rdata == 0, "R6", "lp cleared", lp_rdata, 0);
        check(exp_q.size() == 0, "R2", "bytes left", exp_q.size(), 0);

        // R3 R12: unaligned fragments, junk length bits, empty middle fragment, backpressure
        bp_mode = 1'b1; rdy_mode = 1'b1; mem_lat = 3;
        desc(32'h200, 32'h0, 32'd12);
        seg(32'h200, 0, 32'h901, 32'h2AAA_0000 | 5, 1'b1);
        seg(32'h200, 1, 32'h950, 32'h0000_0000, 1'b1);
        seg(32'h200, 2, 32'h9A3, 32'hD554_0000 | 7, 1'b1);
        d0 = n_dn; t0 = n_txc;
        write_lp(32'h200);
        repeat (4) @(negedge clk);
        write_lp(32'h500);
        wait_end("R3");
        check(n_dn == d0 + 1, "R3", "dn_done count", n_dn, d0 + 1);
        check(n_txc == t0, "R6", "no tx_done without notify", n_txc, t0);
        check(lp_rdata == 0, "R12", "busy write ignored", lp_rdata, 0);
        check(exp_q.size() == 0, "R3", "bytes left", exp_q.size(), 0);
        bp_mode = 1'b0; rdy_mode = 1'b0; mem_lat = 1;

        // R5 R6: empty final fragment, nonzero chain link
        desc(32'h300, 32'h340, 32'h8000 | 6);
        seg(32'h300, 0, 32'hA02, 32'd6, 1'b1);
        seg(32'h300, 1, 32'hB00, 32'h8000_0000, 1'b1);
        d0 = n_dn;
        write_lp(32'h300);
        wait_end("R5");
        check(n_dn == d0 + 1, "R4", "done after empty final", n_dn, d0 + 1);
        check(lp_rdata == 32'h340, "R6", "lp takes link", lp_rdata, 32'h340);
        check(exp_q.size() == 0, "R5", "bytes left", exp_q.size(), 0);

        // R7: length mismatch
        desc(32'h380, 32'h0, 32'd8);
        seg(32'h380, 0, 32'hA10, 32'h8000_0000 | 5, 1'b1);
        d0 = n_dn; h0 = n_herr;
        write_lp(32'h380);
        wait_end("R7");
        check(n_herr == h0 + 1, "R7", "host_err on mismatch", n_herr, h0 + 1);
        check(n_dn == d0, "R7", "no dn_done on mismatch", n_dn, d0);
        check(lp_rdata == 32'h380, "R7", "lp kept", lp_rdata, 32'h380);
        check(exp_q.size() == 0, "R7", "bytes left", exp_q.size(), 0);

        // R8: misaligned address; R12: zero write ignored
        h0 = n_herr; a0 = n_acc;
        write_lp(32'h104);
        repeat (10) @(negedge clk);
        check(n_herr == h0 + 1, "R8", "host_err on misaligned", n_herr, h0 + 1);
        check(n_acc == a0, "R8", "no reads", n_acc, a0);
        check(lp_rdata == 32'h380, "R8", "lp unchanged", lp_rdata, 32'h380);
        write_lp(32'h0);
        repeat (10) @(negedge clk);
        check(n_acc == a0 && lp_rdata == 32'h380, "R12", "zero write ignored", lp_rdata, 32'h380);

        // R9: start while halted
        command(4'd2);
        desc(32'h100, 32'h0, 32'h8000 | 10);
        seg(32'h100, 0, 32'h800, 32'h8000_0000 | 10, 1'b1);
        a0 = n_acc; b0 = n_bytes; d0 = n_dn;
        write_lp(32'h100);
        repeat (30) @(negedge clk);
        check(n_acc == a0, "R9", "no reads while halted", n_acc, a0);
        check(n_bytes == b0, "R9", "no bytes while halted", n_bytes, b0);
        check(lp_rdata == 32'h100, "R9", "lp loaded while halted", lp_rdata, 32'h100);
        command(4'd3);
        wait_end("R9");
        check(n_dn == d0 + 1, "R9", "done after resume", n_dn, d0 + 1);

        // R9: halt mid-packet
        mem_lat = 2;
        desc(32'h180, 32'h0, 32'd40);
        seg(32'h180, 0, 32'hC00, 32'h8000_0000 | 40, 1'b1);
        d0 = n_dn; b0 = n_bytes;
        write_lp(32'h180);
        while (n_bytes < b0 + 5) @(negedge clk);
        command(4'd2);
        @(negedge clk);
        a0 = n_acc;
        repeat (30) @(negedge clk);
        check(n_acc == a0, "R9", "no reads after halt", n_acc, a0);
        check(n_dn == d0, "R9", "no done while halted", n_dn, d0);
        command(4'd3);
        wait_end("R9");
        check(n_dn == d0 + 1, "R9", "done after mid resume", n_dn, d0 + 1);
        check(exp_q.size() == 0, "R9", "bytes left", exp_q.size(), 0);
        mem_lat = 1;

        // R10: fragment list without final flag
        desc(32'h400, 32'h0, 32'd0);
        for (int k = 0; k < 64; k++) seg(32'h400, k, 32'hD00, 32'd0, 1'b0);
        d0 = n_dn; h0 = n_herr;
        write_lp(32'h400);
        wait_end("R10");
        check(n_herr == h0 + 1, "R10", "host_err on runaway list", n_herr, h0 + 1);
        check(n_dn == d0, "R10", "no done on runaway list", n_dn, d0);
        check(lp_rdata == 32'h400, "R10", "lp kept", lp_rdata, 32'h400);

        // R11: never more than one read outstanding
        check(n_overlap == 0, "R11", "overlapping reads", n_overlap, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule